// File: doc/BRIEF.md
# Smart Card Character Framer

This block moves single asynchronous characters between a byte-wide parallel side and one half-duplex smart card I/O line. A character on the line is a start bit in the low (A) state, eight data bits and one parity bit, one elementary time unit (ETU) each. Between characters the line rests high (Z). The transmitter only ever pulls the line low or lets it go, so the line can be wired-AND with the card's own driver. The receiver watches the same line and returns each decoded byte with a parity-error flag.

Three configuration inputs set the character coding, and each can be chosen on its own: bit order, data-level inversion and parity sense. Inversion applies to the eight data bits only, never to the parity bit. The direct convention clears all three inputs. The inverse convention sets all three, and odd parity is what yields the inverted parity bit that convention needs. Bit timing comes from a tick input. `TICKS_PER_ETU` ticks make one ETU, and the receiver samples each bit at mid-ETU. A mode-enable input gates the whole block.

Top module: `scf_framer`

## Requirements
- R1: While `mode_en` is low, `tx_ready` is low, a byte offered on `tx_valid` is not sent, the line stays released (`line_pull` = 0), and no received byte is signalled (`rx_valid` = 0).
- R2: An accepted byte (`tx_valid` and `tx_ready` high at a clock edge) starts a frame at that edge. The frame is one start bit at A (low), eight data bits and one parity bit, each held for `TICKS_PER_ETU` ticks. A is driven as `line_pull` = 1 and Z as release.
- R3: With `cfg_msb_first` = 0 the data bits go out and come in bit 0 first. With `cfg_msb_first` = 1 they go out and come in bit 7 first.
- R4: The line level of a data bit is the logical bit XOR `cfg_invert`, with high (Z) meaning level 1. The parity bit is never inverted.
- R5: The parity line level is the XOR of the eight logical data bits, XOR `cfg_odd`. So `cfg_odd` = 0 gives even parity and 1 gives odd parity.
- R6: After the parity bit the line stays at Z and `tx_ready` stays low for `GUARD_ETU` ETUs. With the default parameters, `tx_ready` returns exactly 48 ticks after the accepting edge.
- R7: The receiver detects a start bit as a high-to-low change between two tick samples. It drops the start if the line is high again at mid-ETU, so a low pulse shorter than half an ETU delivers no byte.
- R8: The receiver samples each data and parity bit at mid-ETU. It decodes them with the same order and inversion rules as the transmitter.
- R9: When the received parity disagrees with R5, the byte is still delivered, with `rx_perr` = 1. A matching parity gives `rx_perr` = 0.
- R10: `rx_valid`, `rx_data` and `rx_perr` hold steady until `rx_ready` is high at a clock edge. A character that arrives entirely while a byte is held is not received.
- R11: The direct-convention setting sends 0x3B as the line sequence A Z Z A Z Z Z A A Z. The inverse-convention setting sends 0x3F as A Z Z A A A A A A Z, and receiving that sequence under the inverse setting gives 0x3F with no parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Smart card framing enable; low clears both directions |
| tick | input | 1 | One-cycle pulse; `TICKS_PER_ETU` pulses make one ETU |
| cfg_msb_first | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| cfg_invert | input | 1 | 1 = data bits inverted on the line |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is held for the consumer |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_perr | output | 1 | Parity mismatch on the held byte |
| line_in | input | 1 | Sampled I/O line level (1 = Z, 0 = A) |
| line_pull | output | 1 | 1 pulls the line to A; 0 releases it |

## Verification
The hardest state to reach is a receiver that has seen a falling edge and must then reject it. Also hard is a receiver holding a byte while a whole new character passes on the line. The block's own transmitter never makes a short low pulse and never sends while a byte is held. So the bench drives the line itself through a wired-AND with `line_pull`. It sends a one-tick low glitch and a character with flipped parity. It also keeps `rx_ready` low across a full second character, then shows that only the first byte comes out. A loopback sweep covers all 256 bytes under all eight coding settings and checks every line bit at mid-ETU against levels computed in the bench.

// File: rtl/scf_pkg.sv
package scf_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_GUARD
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_BITS,
        RX_HOLD
    } rx_st_e;

    // Puts a byte in transmission order: identity for bit-0-first, reversal otherwise.
    function automatic logic [DATA_W-1:0] bit_order(input logic [DATA_W-1:0] v,
                                                    input logic msb_first);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < DATA_W; k++) begin
            r[k] = msb_first ? v[DATA_W-1-k] : v[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/scf_tx.sv
module scf_tx
    import scf_pkg::*;
#(
    parameter int TICKS_PER_ETU = 4,
    parameter int GUARD_ETU     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              msb_first,
    input  logic              invert,
    input  logic              odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_pull
);

    localparam int SUB_W  = $clog2(TICKS_PER_ETU);
    localparam int CNT_MX = (FRAME_BITS > GUARD_ETU) ? FRAME_BITS : GUARD_ETU;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(TICKS_PER_ETU - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] GRD_LAST  = CNT_W'(GUARD_ETU - 1);

    typedef struct packed {
        tx_st_e                st;
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      bits;
        logic [SUB_W-1:0]      sub;
        logic                  pull;
    } tx_s;

    localparam tx_s TX_RST = '{st: TX_IDLE, sh: '1, bits: '0, sub: '0, pull: 1'b0};

    tx_s state_q, state_d;

    logic [DATA_W-1:0] ordered;
    logic [DATA_W-1:0] levels;
    logic              par_lvl;

    always_comb begin
        ordered = bit_order(tx_data, msb_first);
        levels  = ordered ^ {DATA_W{invert}};
        par_lvl = (^tx_data) ^ odd;

        state_d = state_q;
        unique case (state_q.st)
            TX_IDLE: begin
                if (tx_valid) begin
                    state_d.st   = TX_SEND;
                    state_d.sh   = {par_lvl, levels, 1'b0};
                    state_d.bits = '0;
                    state_d.sub  = '0;
                end
            end
            TX_SEND: begin
                if (tick) begin
                    if (state_q.sub == SUB_LAST) begin
                        state_d.sub = '0;
                        state_d.sh  = {1'b1, state_q.sh[FRAME_BITS-1:1]};
                        if (state_q.bits == BIT_LAST) begin
                            state_d.st   = TX_GUARD;
                            state_d.bits = '0;
                        end else begin
                            state_d.bits = state_q.bits + CNT_W'(1);
                        end
                    end else begin
                        state_d.sub = state_q.sub + SUB_W'(1);
                    end
                end
            end
            TX_GUARD: begin
                if (tick) begin
                    if (state_q.sub == SUB_LAST) begin
                        state_d.sub = '0;
                        if (state_q.bits == GRD_LAST) begin
                            state_d.st = TX_IDLE;
                        end else begin
                            state_d.bits = state_q.bits + CNT_W'(1);
                        end
                    end else begin
                        state_d.sub = state_q.sub + SUB_W'(1);
                    end
                end
            end
            default: state_d = TX_RST;
        endcase

        if (!en) begin
            state_d = TX_RST;
        end
        state_d.pull = (state_d.st == TX_SEND) && !state_d.sh[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_ready  = en && (state_q.st == TX_IDLE);
    assign line_pull = state_q.pull;

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> line_pull)
        else $error("start bit not driven after accept");

    assert_released_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !line_pull)
        else $error("line pulled while disabled");

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> !tx_ready)
        else $error("ready while frame on line");

endmodule

// File: rtl/scf_rx.sv
module scf_rx
    import scf_pkg::*;
#(
    parameter int TICKS_PER_ETU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              msb_first,
    input  logic              invert,
    input  logic              odd,
    input  logic              line_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    input  logic              rx_ready
);

    localparam int SUB_W = $clog2(TICKS_PER_ETU);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_ETU - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(TICKS_PER_ETU / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W);

    typedef struct packed {
        rx_st_e            st;
        logic [DATA_W:0]   sh;
        logic [CNT_W-1:0]  bits;
        logic [SUB_W-1:0]  sub;
        logic              last;
        logic [DATA_W-1:0] data;
        logic              perr;
    } rx_s;

    localparam rx_s RX_RST = '{st: RX_HUNT, sh: '0, bits: '0, sub: '0,
                               last: 1'b0, data: '0, perr: 1'b0};

    rx_s state_q, state_d;

    logic [DATA_W:0]   sh_next;
    logic [DATA_W-1:0] logical;
    logic [DATA_W-1:0] decoded;

    always_comb begin
        sh_next = {line_in, state_q.sh[DATA_W:1]};
        logical = sh_next[DATA_W-1:0] ^ {DATA_W{invert}};
        decoded = bit_order(logical, msb_first);

        state_d = state_q;
        unique case (state_q.st)
            RX_HUNT: begin
                if (tick) begin
                    state_d.last = line_in;
                    if (state_q.last && !line_in) begin
                        state_d.st  = RX_START;
                        state_d.sub = '0;
                    end
                end
            end
            RX_START: begin
                if (tick) begin
                    if (state_q.sub == SUB_MID) begin
                        state_d.sub = '0;
                        if (!line_in) begin
                            state_d.st   = RX_BITS;
                            state_d.bits = '0;
                        end else begin
                            state_d.st   = RX_HUNT;
                            state_d.last = 1'b1;
                        end
                    end else begin
                        state_d.sub = state_q.sub + SUB_W'(1);
                    end
                end
            end
            RX_BITS: begin
                if (tick) begin
                    if (state_q.sub == SUB_LAST) begin
                        state_d.sub = '0;
                        state_d.sh  = sh_next;
                        if (state_q.bits == BIT_LAST) begin
                            state_d.st   = RX_HOLD;
                            state_d.data = decoded;
                            state_d.perr = ((^decoded) ^ odd) != sh_next[DATA_W];
                        end else begin
                            state_d.bits = state_q.bits + CNT_W'(1);
                        end
                    end else begin
                        state_d.sub = state_q.sub + SUB_W'(1);
                    end
                end
            end
            RX_HOLD: begin
                if (rx_ready) begin
                    state_d.st   = RX_HUNT;
                    state_d.last = 1'b0;
                end
            end
            default: state_d = RX_RST;
        endcase

        if (!en) begin
            state_d = RX_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_valid = (state_q.st == RX_HOLD);
    assign rx_data  = state_q.data;
    assign rx_perr  = state_q.perr;

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_perr)))
        else $error("held byte changed before accept");

    assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rx_valid)
        else $error("byte signalled while disabled");

endmodule

// File: rtl/scf_framer.sv
module scf_framer
    import scf_pkg::*;
#(
    parameter int TICKS_PER_ETU = 4,
    parameter int GUARD_ETU     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  logic       tick,
    input  logic       cfg_msb_first,
    input  logic       cfg_invert,
    input  logic       cfg_odd,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic       rx_perr,
    input  logic       line_in,
    output logic       line_pull
);

    initial begin
        assert (TICKS_PER_ETU >= 2 && GUARD_ETU >= 1)
            else $error("TICKS_PER_ETU must be >= 2 and GUARD_ETU >= 1");
    end

    scf_tx #(
        .TICKS_PER_ETU(TICKS_PER_ETU),
        .GUARD_ETU    (GUARD_ETU)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_en),
        .tick     (tick),
        .msb_first(cfg_msb_first),
        .invert   (cfg_invert),
        .odd      (cfg_odd),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_pull(line_pull)
    );

    scf_rx #(
        .TICKS_PER_ETU(TICKS_PER_ETU)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_en),
        .tick     (tick),
        .msb_first(cfg_msb_first),
        .invert   (cfg_invert),
        .odd      (cfg_odd),
        .line_in  (line_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .rx_ready (rx_ready)
    );

endmodule

// File: tb/scf_framer_test.sv
module scf_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b1;
    logic       tick = 1'b1;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       rx_perr;
    logic       line_pull;
    logic       drv = 1'b1;
    logic       line;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    int cycles = 0;
    bit done = 0;
    logic [9:0] cap;

    assign line = drv & ~line_pull;

    always #5 clk = ~clk;

    scf_framer #(.TICKS_PER_ETU(4), .GUARD_ETU(2)) uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .tick(tick),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_odd(cfg_odd),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_perr(rx_perr),
        .line_in(line), .line_pull(line_pull)
    );

    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        tick = (tick_div == 1) ? 1'b1 : (tick_cnt == 0);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] frame_levels(input logic [7:0] d, input logic msb,
                                                input logic inv, input logic odd);
        logic [9:0] f;
        f[0] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            f[k+1] = (msb ? d[7-k] : d[k]) ^ inv;
        end
        f[9] = (^d) ^ odd;
        return f;
    endfunction

    task automatic set_cfg(input logic msb, input logic inv, input logic odd);
        cfg_msb_first = msb;
        cfg_invert = inv;
        cfg_odd = odd;
    endtask

    task automatic take_rx();
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
    endtask

    // Sends one byte through loopback; with timing_chk, samples each bit at mid-ETU.
    task automatic send_frame(input logic [7:0] d, input bit timing_chk, input string req);
        logic [9:0] exp_lv;
        bit guard_ok;
        exp_lv = frame_levels(d, cfg_msb_first, cfg_invert, cfg_odd);
        @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        if (timing_chk) begin
            repeat (2) @(negedge clk);
            for (int j = 0; j < 10; j++) begin
                cap[j] = line;
                if (j < 9) repeat (4) @(negedge clk);
            end
            chk(cap == exp_lv, {req, " R2 R3 R4 R5 line bits"}, cap, exp_lv);
            guard_ok = 1;
            for (int c = 39; c < 48; c++) begin
                @(negedge clk);
                if (tx_ready) guard_ok = 0;
                if (c >= 40 && line !== 1'b1) guard_ok = 0;
            end
            @(negedge clk);
            chk(guard_ok && tx_ready, "R6 guard and ready at tick 48", tx_ready, 1);
        end else begin
            while (!tx_ready) @(negedge clk);
        end
        chk(rx_valid && rx_data == d && !rx_perr, {req, " R8 loopback receive"},
            {rx_valid, rx_perr, rx_data}, {2'b10, d});
        take_rx();
    endtask

    // Drives a character from the card side (4 cycles per bit, tick every cycle).
    task automatic drive_frame(input logic [7:0] d, input bit flip_par);
        logic [9:0] lv;
        lv = frame_levels(d, cfg_msb_first, cfg_invert, cfg_odd);
        lv[9] = lv[9] ^ flip_par;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk) drv = lv[j];
            repeat (3) @(negedge clk);
        end
        @(negedge clk) drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_levels(input logic [9:0] lv);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk) drv = lv[j];
            repeat (3) @(negedge clk);
        end
        @(negedge clk) drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state
        chk(tx_ready && !rx_valid && line && !rx_perr, "R1 reset state",
            {tx_ready, rx_valid, line}, 3'b101);

        // R11: the two initial-character waveforms
        set_cfg(0, 0, 0);
        send_frame(8'h3B, 1, "R11 direct");
        chk(cap == 10'b1001110110, "R11 direct 3B waveform", cap, 10'b1001110110);
        set_cfg(1, 1, 1);
        send_frame(8'h3F, 1, "R11 inverse");
        chk(cap == 10'b1000000110, "R11 inverse 3F waveform", cap, 10'b1000000110);
        drive_levels(10'b1000000110);
        chk(rx_valid && rx_data == 8'h3F && !rx_perr, "R11 receive inverse 3F",
            {rx_perr, rx_data}, 9'h03F);
        take_rx();

        // R3 R4 R5 R8: every byte under every coding setting
        for (int cfg = 0; cfg < 8; cfg++) begin
            set_cfg(cfg[2], cfg[1], cfg[0]);
            for (int d = 0; d < 256; d++) begin
                send_frame(d[7:0], 1, "sweep");
            end
        end

        // R9: wrong parity from the card side, in both senses
        set_cfg(0, 0, 0);
        drive_frame(8'h5A, 1);
        chk(rx_valid && rx_data == 8'h5A && rx_perr, "R9 even mismatch flagged",
            {rx_perr, rx_data}, 9'h15A);
        take_rx();
        set_cfg(1, 0, 1);
        drive_frame(8'hC3, 1);
        chk(rx_valid && rx_data == 8'hC3 && rx_perr, "R9 odd mismatch flagged",
            {rx_perr, rx_data}, 9'h1C3);
        take_rx();
        drive_frame(8'hC3, 0);
        chk(rx_valid && !rx_perr, "R9 odd match clean", rx_perr, 0);
        take_rx();

        // R7: a one-tick low glitch is rejected, the next character is still received
        set_cfg(0, 0, 0);
        @(negedge clk) drv = 1'b0;
        @(negedge clk) drv = 1'b1;
        repeat (60) @(negedge clk);
        chk(!rx_valid, "R7 glitch rejected", rx_valid, 0);
        drive_frame(8'h81, 0);
        chk(rx_valid && rx_data == 8'h81 && !rx_perr, "R7 receive after glitch",
            rx_data, 8'h81);

        // R10: held byte is stable and a character during hold is lost
        repeat (50) @(negedge clk);
        chk(rx_valid && rx_data == 8'h81, "R10 held without accept", rx_data, 8'h81);
        drive_frame(8'h7E, 1);
        chk(rx_valid && rx_data == 8'h81 && !rx_perr, "R10 hold unchanged by new char",
            {rx_perr, rx_data}, 9'h081);
        take_rx();
        repeat (8) @(negedge clk);
        chk(!rx_valid, "R10 char during hold not received", rx_valid, 0);

        // R1: disabled block ignores both sides
        @(negedge clk) mode_en = 1'b0;
        tx_data = 8'hFF;
        tx_valid = 1'b1;
        begin
            bit quiet;
            quiet = 1;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (tx_ready || !line) quiet = 0;
            end
            chk(quiet, "R1 tx ignored while disabled", {tx_ready, line}, 2'b01);
        end
        tx_valid = 1'b0;
        drive_frame(8'h24, 0);
        chk(!rx_valid, "R1 rx ignored while disabled", rx_valid, 0);
        @(negedge clk) mode_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R8: sparse tick rate through loopback
        tick_div = 3;
        set_cfg(1, 0, 1);
        send_frame(8'hA5, 0, "R2 sparse tick");
        tick_div = 1;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule